// File: doc/BRIEF.md
# Descriptor Chain Autoload Engine

This block serves one DMA channel. It walks a chain of transfer descriptors held in memory and copies each one into the channel's working parameter registers. It does this between transfer blocks, so no processor has to step in. Software writes the head descriptor address and the head descriptor's shape, then sets the enable bit. From then on the engine alternates between two phases. In the fetch phase it reads a descriptor over a word-read memory port and streams its fields to the working registers. In the run phase it starts one block on the external transfer datapath and waits until that block completes.

Descriptors differ in size. Each descriptor's element-count word states the type and the address-valid flags of the descriptor that follows it, so the engine knows how many words to read next and where each word belongs. A pointer word with its low bit set makes the engine stop after that node. In that case the engine raises a pause status and waits for software. A reserved pointer value ends the chain. Fast mode loads the head descriptor before any block runs. Without fast mode, the block already held in the registers runs first.

Top module: `desc_autoload`

## Requirements
- R1: The register map has four registers. Address 0 is list control: bit 0 is the destination-valid flag, bit 2 is the source-valid flag, bits 5:4 are the head type, bit 7 is pause, bit 8 is list mode and bit 10 is fast mode. Address 1 is the next-descriptor pointer. Address 2 is the 16-bit completed-node counter. Address 3 bit 0 is the channel enable. All four read back as zero after reset.
- R2: A node fetch reads words from the pointer address with bits 1:0 forced to zero, at strictly ascending word addresses, with one request in flight at a time. It reads 2 common words plus a payload of 12, 8, 7, 2 or 1 words.
- R3: The payload size follows from the type and the flags. Type 1 (and type 0) is the full set of 12 words. Type 2 is 8 words when both flags are set and 7 otherwise. Type 3 is 2 words when both flags are set and 1 otherwise. For the 12-, 8- and 2-word forms, payload word k is written to field code k.
- R4: In the single-address forms, the lone address word goes to field 0 (source) when the source flag is set, and to field 1 (destination) otherwise. In the 7-word form, payload word k≥1 goes to field k+1.
- R5: In fast mode the head descriptor is fetched before the first block start.
- R6: With fast mode off, the first event is a block start for the preloaded block. The head is fetched after that block is done, and the preloaded block is not counted.
- R7: In node N's count word, bits 30:29 are the type of node N+1, bit 24 is its source flag and bit 26 is its destination flag. The word itself is delivered as field 12 with bits 31:24 cleared.
- R8: The counter increases by one each time a node's block completes. A software write to the counter loads it, and the software write wins over an increment in the same cycle.
- R9: A node whose pointer word has bit 0 set ends in pause. After its block completes, control bit 7 is set, the enable is cleared and no further request or block start is issued. Clearing bit 7 and setting the enable resumes the chain at the stored pointer.
- R10: A node whose pointer word equals 0xFFFFFFFC, with bits 1:0 ignored, ends the chain. After its block completes, the enable is cleared and list_done pulses for one cycle. This check takes priority over pause.
- R11: Bit 28 in node N's count word makes blk_end pulse for one cycle when node N+1's block completes.
- R12: The engine starts only when the enable bit, the list-mode bit and a clear pause bit are all present. Setting the enable with list mode off issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request (one-cycle pulse) |
| mem_addr | output | DW | Descriptor word byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response data |
| blk_start | output | 1 | Start one transfer block (pulse) |
| blk_done | input | 1 | Transfer block finished (pulse) |
| fld_we | output | 1 | Working-register field write |
| fld_sel | output | 4 | Field code of the write |
| fld_data | output | DW | Field value |
| paused | output | 1 | Pause status |
| blk_end | output | 1 | Block-end notification pulse |
| list_done | output | 1 | Chain-completed pulse |

## Verification
The bench builds the engine with its default values, DW=32 and CW=16. This gives the 0xFFFFFFFC end marker and the count-word flag positions their full widths, so real descriptor images can be stored in a sparse memory model. One chain runs all five descriptor shapes in fast mode, including both single-address steerings. A second chain starts with a preloaded block, stops in pause partway and then resumes. These two chains cover the start orderings, the notify staging across node boundaries and the pause and resume path. They also cover the counter, which is reloaded by software between runs.

// File: rtl/dl_pkg.sv
package dl_pkg;

  typedef enum logic [2:0] {
    K_FULL     = 3'd0,
    K_PAIR_IDX = 3'd1,
    K_ONE_IDX  = 3'd2,
    K_PAIR     = 3'd3,
    K_ONE      = 3'd4
  } kind_e;

  typedef struct packed {
    logic       fast;
    logic       lmode;
    logic       pause;
    logic [1:0] htype;
    logic       src_v;
    logic       dst_v;
  } ctl_t;

  localparam logic [3:0] FLD_COUNT = 4'd12;

  function automatic kind_e kind_of(input logic [1:0] t, input logic s, input logic d);
    kind_e k;
    case (t)
      2'd2:    k = (s && d) ? K_PAIR_IDX : K_ONE_IDX;
      2'd3:    k = (s && d) ? K_PAIR : K_ONE;
      default: k = K_FULL;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] payload_len(input kind_e k);
    logic [3:0] n;
    case (k)
      K_PAIR_IDX: n = 4'd8;
      K_ONE_IDX:  n = 4'd7;
      K_PAIR:     n = 4'd2;
      K_ONE:      n = 4'd1;
      default:    n = 4'd12;
    endcase
    return n;
  endfunction

  function automatic logic [3:0] field_code(input kind_e k, input logic [3:0] w, input logic s);
    logic [3:0] c;
    case (k)
      K_ONE_IDX: c = (w == 4'd0) ? {3'b000, ~s} : w + 4'd1;
      K_ONE:     c = {3'b000, ~s};
      default:   c = w;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dl_regs.sv
module dl_regs
  import dl_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_pause_set,
  input  logic          eng_en_clr,
  input  logic          eng_cnt_inc,
  input  logic          eng_ptr_ld,
  input  logic [DW-1:0] eng_ptr_val,
  output ctl_t          ctl,
  output logic [DW-1:0] nptr,
  output logic          en,
  output logic [CW-1:0] cnt
);
  localparam int PADW = DW - 11;

  ctl_t          ctl_q, ctl_d;
  logic [DW-1:0] nptr_q, nptr_d;
  logic          en_q, en_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ctl_d  = ctl_q;
    nptr_d = nptr_q;
    en_d   = en_q;
    cnt_d  = cnt_q;
    if (wr && addr == 2'd0) begin
      ctl_d.dst_v = wdata[0];
      ctl_d.src_v = wdata[2];
      ctl_d.htype = wdata[5:4];
      ctl_d.pause = wdata[7];
      ctl_d.lmode = wdata[8];
      ctl_d.fast  = wdata[10];
    end
    if (eng_pause_set) ctl_d.pause = 1'b1;
    if (wr && addr == 2'd1) nptr_d = wdata;
    if (eng_ptr_ld)         nptr_d = eng_ptr_val;
    if (wr && addr == 2'd3) en_d = wdata[0];
    if (eng_en_clr)         en_d = 1'b0;
    if (eng_cnt_inc)        cnt_d = cnt_q + 1'b1;
    if (wr && addr == 2'd2) cnt_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      nptr_q <= '0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      nptr_q <= nptr_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = {{PADW{1'b0}}, ctl_q.fast, 1'b0, ctl_q.lmode, ctl_q.pause, 1'b0,
                     ctl_q.htype, 1'b0, ctl_q.src_v, 1'b0, ctl_q.dst_v};
      2'd1: rdata = nptr_q;
      2'd2: rdata = {{(DW-CW){1'b0}}, cnt_q};
      default: rdata = {{(DW-1){1'b0}}, en_q};
    endcase
  end

  assign ctl  = ctl_q;
  assign nptr = nptr_q;
  assign en   = en_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/dl_fetch.sv
module dl_fetch #(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] base,
  input  logic [IW-1:0] nwords,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          word_vld,
  output logic [IW-1:0] word_idx,
  output logic [DW-1:0] word_data,
  output logic          last
);
  logic          busy_q, busy_d;
  logic          req_q, req_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          accept;

  assign accept = busy_q && !req_q && mem_rvalid;

  always_comb begin
    busy_d = busy_q;
    req_d  = 1'b0;
    addr_d = addr_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      req_d  = 1'b1;
      addr_d = {base[DW-1:2], 2'b00};
      idx_d  = '0;
    end else if (accept) begin
      if (idx_q == nwords - 1'b1) begin
        busy_d = 1'b0;
      end else begin
        req_d  = 1'b1;
        addr_d = addr_q + DW'(4);
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign word_vld  = accept;
  assign word_idx  = idx_q;
  assign word_data = mem_rdata;
  assign last      = accept && (idx_q == nwords - 1'b1);
endmodule

// File: rtl/desc_autoload.sv
module desc_autoload
  import dl_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          blk_start,
  input  logic          blk_done,
  output logic          fld_we,
  output logic [3:0]    fld_sel,
  output logic [DW-1:0] fld_data,
  output logic          paused,
  output logic          blk_end,
  output logic          list_done
);
  localparam int IW = 4;
  localparam logic [DW-3:0] END_HI = {(DW-2){1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FETCH, S_RUN} st_e;

  ctl_t          ctl;
  logic [DW-1:0] nptr;
  logic          en_w;
  logic [CW-1:0] cnt_w;
  logic          pause_set, en_clr, cnt_inc, ptr_ld, f_start;
  logic          w_vld, w_last;
  logic [IW-1:0] w_idx, nwords;
  logic [DW-1:0] w_data;

  st_e           st_q, st_d;
  kind_e         kind_q, kind_d, nkind_q, nkind_d;
  logic          src_q, src_d, nsrc_q, nsrc_d, nntf_q, nntf_d;
  logic          pend_q, pend_d, cur_q, cur_d, inl_q, inl_d;
  logic [DW-1:0] ptrw_q, ptrw_d;
  logic          bs_q, bs_d, be_q, be_d, ld_q, ld_d;

  dl_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .eng_pause_set(pause_set), .eng_en_clr(en_clr),
    .eng_cnt_inc(cnt_inc), .eng_ptr_ld(ptr_ld), .eng_ptr_val(ptrw_q),
    .ctl(ctl), .nptr(nptr), .en(en_w), .cnt(cnt_w)
  );

  assign nwords = 4'd2 + payload_len(kind_q);

  dl_fetch #(.DW(DW), .IW(IW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(f_start), .base(nptr), .nwords(nwords),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .word_vld(w_vld), .word_idx(w_idx),
    .word_data(w_data), .last(w_last)
  );

  // field steering: word 1 is the count word, payload from word 2 on
  assign fld_we   = w_vld && (w_idx != '0);
  assign fld_sel  = (w_idx == 4'd1) ? FLD_COUNT : field_code(kind_q, w_idx - 4'd2, src_q);
  assign fld_data = (w_idx == 4'd1) ? {8'h00, w_data[23:0]} : w_data;

  always_comb begin
    st_d = st_q;  kind_d = kind_q;  src_d = src_q;
    nkind_d = nkind_q;  nsrc_d = nsrc_q;  nntf_d = nntf_q;
    ptrw_d = ptrw_q;  pend_d = pend_q;  cur_d = cur_q;  inl_d = inl_q;
    bs_d = 1'b0;  be_d = 1'b0;  ld_d = 1'b0;
    f_start = 1'b0;  pause_set = 1'b0;  en_clr = 1'b0;  cnt_inc = 1'b0;  ptr_ld = 1'b0;
    if (w_vld && w_idx == 4'd0) ptrw_d = w_data;
    if (w_vld && w_idx == 4'd1) begin
      nkind_d = kind_of(w_data[30:29], w_data[24], w_data[26]);
      nsrc_d  = w_data[24];
      nntf_d  = w_data[28];
    end
    case (st_q)
      S_IDLE: if (en_w && ctl.lmode && !ctl.pause) begin
        if (!inl_q) begin
          inl_d  = 1'b1;
          kind_d = kind_of(ctl.htype, ctl.src_v, ctl.dst_v);
          src_d  = ctl.src_v;
          pend_d = 1'b0;
          cur_d  = 1'b0;
          if (ctl.fast) begin
            f_start = 1'b1;  st_d = S_FETCH;
          end else begin
            bs_d = 1'b1;  st_d = S_PRE;
          end
        end else begin
          f_start = 1'b1;  st_d = S_FETCH;
        end
      end
      S_PRE: if (blk_done) begin
        f_start = 1'b1;  st_d = S_FETCH;
      end
      S_FETCH: if (w_last) begin
        ptr_ld = 1'b1;
        kind_d = nkind_q;
        src_d  = nsrc_q;
        cur_d  = pend_q;
        pend_d = nntf_q;
        bs_d   = 1'b1;
        st_d   = S_RUN;
      end
      S_RUN: if (blk_done) begin
        cnt_inc = 1'b1;
        be_d    = cur_q;
        if (ptrw_q[DW-1:2] == END_HI) begin
          en_clr = 1'b1;  ld_d = 1'b1;  inl_d = 1'b0;  st_d = S_IDLE;
        end else if (ptrw_q[0]) begin
          pause_set = 1'b1;  en_clr = 1'b1;  st_d = S_IDLE;
        end else begin
          f_start = 1'b1;  st_d = S_FETCH;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kind_q <= K_FULL;  src_q <= 1'b0;
      nkind_q <= K_FULL;  nsrc_q <= 1'b0;  nntf_q <= 1'b0;
      ptrw_q <= '0;  pend_q <= 1'b0;  cur_q <= 1'b0;  inl_q <= 1'b0;
      bs_q <= 1'b0;  be_q <= 1'b0;  ld_q <= 1'b0;
    end else begin
      st_q <= st_d;  kind_q <= kind_d;  src_q <= src_d;
      nkind_q <= nkind_d;  nsrc_q <= nsrc_d;  nntf_q <= nntf_d;
      ptrw_q <= ptrw_d;  pend_q <= pend_d;  cur_q <= cur_d;  inl_q <= inl_d;
      bs_q <= bs_d;  be_q <= be_d;  ld_q <= ld_d;
    end
  end

  assign blk_start = bs_q;
  assign blk_end   = be_q;
  assign list_done = ld_q;
  assign paused    = ctl.pause;
endmodule

// File: rtl/dl_chk.sv
module dl_chk #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          blk_start,
  input logic          fld_we,
  input logic          paused,
  input logic          list_done,
  input logic          en_w,
  input logic [CW-1:0] cnt_w
);
  logic          out_q;
  logic          seq_q;
  logic [DW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      seq_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (mem_req)                 out_q <= 1'b1;
      else if (mem_rvalid)         out_q <= 1'b0;
      if (mem_req) begin
        seq_q  <= 1'b1;
        last_q <= mem_addr;
      end else if (blk_start || reg_wr) begin
        seq_q  <= 1'b0;
      end
    end
  end

  p_one_in_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_q);
  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && seq_q) |-> mem_addr == last_q + DW'(4));
  p_no_load_in_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fld_we |-> !blk_start);
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> (cnt_w == $past(cnt_w) || cnt_w == $past(cnt_w) + 1'b1));
  p_pause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!mem_req && !blk_start));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);
  p_done_disables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> !en_w);
endmodule

bind desc_autoload dl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .blk_start(blk_start),
  .fld_we(fld_we), .paused(paused), .list_done(list_done),
  .en_w(en_w), .cnt_w(cnt_w)
);

// File: tb/test_desc_autoload.sv
`timescale 1ns/1ps
module test_desc_autoload;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          mem_req;
  logic [DW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          blk_start;
  logic          blk_done = 1'b0;
  logic          fld_we;
  logic [3:0]    fld_sel;
  logic [DW-1:0] fld_data;
  logic          paused, blk_end, list_done;

  always #2.5 clk = ~clk;

  desc_autoload i_desc_autoload (.*);

  int nvec = 0, nbad = 0, cyc = 0;
  int n_req = 0, n_bs = 0, n_be = 0, n_ld = 0;
  bit watch = 0, first_is_req = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_a[$];
  logic [35:0] exp_f[$];
  int ntyp[8]; bit nsrc[8], ndst[8], nntf[8], npau[8];
  int dp = 0;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory and datapath models, flop-like
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    if (blk_start) dp <= 3;
    else if (dp != 0) dp <= dp - 1;
    blk_done <= (dp == 1) && !blk_start;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (watch && (mem_req || blk_start)) begin first_is_req = mem_req; watch = 0; end
    if (mem_req) begin
      n_req++;
      if (exp_a.size() == 0) chk("R2 unexpected request", {4'h0, mem_addr}, 36'h0);
      else chk("R2 request address", {4'h0, mem_addr}, {4'h0, exp_a.pop_front()});
    end
    if (fld_we) begin
      if (exp_f.size() == 0) chk("R3 unexpected field", {fld_sel, fld_data}, 36'h0);
      else chk("R3 R4 R7 field", {fld_sel, fld_data}, exp_f.pop_front());
    end
    if (blk_start) n_bs++;
    if (blk_end) n_be++;
    if (list_done) n_ld++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int ekind(input int t, input bit s, input bit d);
    if (t == 2) return (s && d) ? 1 : 2;
    if (t == 3) return (s && d) ? 3 : 4;
    return 0;
  endfunction

  function automatic int elen(input int k);
    case (k) 1: return 8; 2: return 7; 3: return 2; 4: return 1; default: return 12; endcase
  endfunction

  function automatic int ecode(input int k, input int w, input bit s);
    if (k == 4) return s ? 0 : 1;
    if (k == 2) return (w == 0) ? (s ? 0 : 1) : w + 1;
    return w;
  endfunction

  // driver: lays out the chain in memory and queues the expected traffic
  task automatic load_list(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a, ptr, cw, data;
      int k, len;
      a = base + 32'(i * 64);
      k = ekind(ntyp[i], nsrc[i], ndst[i]);
      len = elen(k);
      ptr = (i == n - 1) ? 32'hFFFF_FFFC : base + 32'((i + 1) * 64);
      ptr[0] = npau[i];
      cw = 32'h0000_0100 + 32'(i) + 32'h0100_0000;
      cw[31:24] = 8'h00;
      if (i < n - 1) begin
        cw[30:29] = 2'(ntyp[i + 1]);
        cw[24] = nsrc[i + 1];
        cw[26] = ndst[i + 1];
        cw[28] = nntf[i + 1];
      end
      mem[a] = ptr;
      mem[a + 4] = cw;
      exp_a.push_back(a);
      exp_a.push_back(a + 4);
      exp_f.push_back({4'd12, cw & 32'h00FF_FFFF});
      for (int w = 0; w < len; w++) begin
        data = {base[15:8], 8'(i), 8'h5A, 8'(w)};
        mem[a + 8 + 32'(4 * w)] = data;
        exp_a.push_back(a + 8 + 32'(4 * w));
        exp_f.push_back({4'(ecode(k, w, nsrc[i])), data});
      end
    end
  endtask

  task automatic wait_stop;
    int l0 = n_ld;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (n_ld != l0 || paused) break;
    end
  endtask

  function automatic logic [31:0] head_ctl(input bit fast);
    return 32'h100 | (fast ? 32'h400 : 32'h0) | 32'(ntyp[0] << 4) | 32'(nsrc[0] << 2) | 32'(ndst[0]);
  endfunction

  initial begin
    logic [31:0] v;
    int bs0, be0, ld0, rq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", {4'h0, v}, 36'h0);
    end
    chk("R1 reset outputs", {33'h0, paused, blk_end, list_done}, 36'h0);

    // chain A: fast mode, all five shapes
    ntyp = '{1, 2, 2, 3, 3, 0, 0, 0};
    nsrc = '{1, 1, 1, 1, 0, 0, 0, 0};
    ndst = '{1, 1, 0, 1, 1, 0, 0, 0};
    nntf = '{0, 1, 0, 1, 0, 0, 0, 0};
    npau = '{0, 0, 0, 0, 0, 0, 0, 0};
    load_list(5, 32'h0000_1000);
    bs0 = n_bs; be0 = n_be; ld0 = n_ld;
    wr(2'd1, 32'h0000_1002);
    wr(2'd0, head_ctl(1));
    wr(2'd2, 32'h0);
    watch = 1;
    wr(2'd3, 32'h1);
    wait_stop();
    chk("R5 fetch precedes first start", {35'h0, first_is_req}, 36'h1);
    chk("R10 list_done pulses", 36'(n_ld - ld0), 36'd1);
    rd(2'd3, v); chk("R10 enable cleared", {4'h0, v}, 36'h0);
    rd(2'd2, v); chk("R8 counter after chain", {4'h0, v}, 36'd5);
    chk("R8 block starts", 36'(n_bs - bs0), 36'd5);
    chk("R11 notify pulses", 36'(n_be - be0), 36'd2);
    chk("R2 all words fetched", 36'(exp_a.size() + exp_f.size()), 36'd0);

    // R12: enable with list mode off
    rq0 = n_req; bs0 = n_bs;
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    repeat (15) @(negedge clk);
    chk("R12 no activity without list mode", 36'((n_req - rq0) + (n_bs - bs0)), 36'd0);
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0000_ABCD);
    rd(2'd2, v); chk("R8 software load", {4'h0, v}, 36'h0ABCD);

    // chain B: preloaded block first, pause after node 1
    ntyp = '{3, 2, 1, 0, 0, 0, 0, 0};
    nsrc = '{1, 0, 0, 0, 0, 0, 0, 0};
    ndst = '{0, 1, 0, 0, 0, 0, 0, 0};
    nntf = '{0, 0, 1, 0, 0, 0, 0, 0};
    npau = '{0, 1, 0, 0, 0, 0, 0, 0};
    load_list(3, 32'h0000_2000);
    bs0 = n_bs; be0 = n_be; ld0 = n_ld;
    wr(2'd1, 32'h0000_2000);
    wr(2'd0, head_ctl(0));
    wr(2'd2, 32'h0);
    watch = 1;
    wr(2'd3, 32'h1);
    wait_stop();
    chk("R6 preloaded block first", {35'h0, first_is_req}, 36'h0);
    chk("R9 paused output", {35'h0, paused}, 36'h1);
    rd(2'd0, v); chk("R9 pause bit in control", {35'h0, v[7]}, 36'h1);
    rd(2'd3, v); chk("R9 enable cleared", {4'h0, v}, 36'h0);
    rd(2'd2, v); chk("R6 counter excludes preload", {4'h0, v}, 36'd2);
    rq0 = n_req;
    repeat (20) @(negedge clk);
    chk("R9 no requests while paused", 36'(n_req - rq0), 36'd0);
    wr(2'd0, head_ctl(0));
    wr(2'd3, 32'h1);
    wait_stop();
    chk("R9 resumed chain ends", 36'(n_ld - ld0), 36'd1);
    rd(2'd2, v); chk("R8 counter after resume", {4'h0, v}, 36'd3);
    chk("R6 block starts incl preload", 36'(n_bs - bs0), 36'd4);
    chk("R11 notify on node 2", 36'(n_be - be0), 36'd1);
    chk("R2 all words fetched B", 36'(exp_a.size() + exp_f.size()), 36'd0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule